// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between an internal request port and an 8-bit asynchronous NAND flash bus. Each request names one bus operation: a single command byte, a full five-cycle address, a burst of bytes to write, a burst of bytes to read, or a standby interval. The block then produces the chip-select, the two latch-enable levels, the write and read strobes and the data-bus driver enable for that operation.

The low and high phases of every strobe are set in system clocks by two small configuration inputs, and never drop below two clocks. Write data is pulled from the host one byte at a time through a take pulse. Read data is returned with a one-cycle valid pulse per byte.

A protect input drives the flash write-protect pin as a static level. While protect is asserted, the block refuses requests that would start a program or erase sequence. Standby keeps chip-select deasserted for a programmable number of clocks before the block reports idle again.

Top module: `nand_bus_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, fl_ce_n, fl_we_n and fl_re_n are 1; fl_cle, fl_ale and fl_dq_oe are 0; busy is 0 and req_ready is 1.
- R2: A request with req_op=0 (command) gives one write-strobe pulse. During the pulse fl_ce_n=0, fl_cle=1, fl_ale=0 and fl_re_n=1, and fl_dq_o equals req_byte when fl_we_n rises.
- R3: A request with req_op=1 (address) gives exactly five write-strobe pulses with fl_ale=1, fl_cle=0 and fl_ce_n=0. The bytes are: req_addr[7:0], then {4'b0, req_addr[11:8]}, then the row field req_addr[30:12] in three bytes, least significant byte first. The last byte has its top five bits, including bit 7, at zero.
- R4: A request with req_op=2 (data in) gives req_len+1 write-strobe pulses with both latch enables low, fl_re_n=1 and fl_wp_n=1. wr_take pulses once per byte. The bytes are taken from wr_byte in order: the first in the accept cycle, each later one in the clock that starts its strobe.
- R5: A request with req_op=3 (data out) gives req_len+1 read-strobe pulses with fl_we_n=1, both latch enables low and fl_dq_oe=0 while fl_ce_n=0. Each pulse yields one rd_valid pulse, and rd_data is the value of fl_dq_i in the last clock before fl_re_n rises.
- R6: Each write or read strobe stays low for max(cfg_lo,2) clocks and high for max(cfg_hi,2) clocks. This holds between bytes and after the last byte, until chip-select rises.
- R7: When prot_en=1, a data-in request, or a command request with req_modify=1, is accepted but refused. It produces no strobe, fl_ce_n stays 1, busy stays 0, and req_denied pulses for one clock. Reads, addresses and commands with req_modify=0 still run.
- R8: fl_wp_n is the inverse of prot_en at all times, independent of strobe timing.
- R9: A request with req_op of 4 to 7 (standby) keeps fl_ce_n=1 and busy=1 for max(cfg_standby,2) clocks, and then returns to idle.
- R10: req_ready is high exactly when busy is low. An accepted operation that runs holds busy for 1+n*(low+high) clocks, where n is its byte count. fl_ce_n falls one clock before the first strobe falls, and busy falls in the clock where fl_ce_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 3 | 0 command, 1 address, 2 data in, 3 data out, 4-7 standby |
| req_modify | input | 1 | Command starts a program or erase |
| req_byte | input | 8 | Command byte |
| req_addr | input | 31 | Column (low 12 bits) and row (upper 19 bits) address |
| req_len | input | 8 | Burst length minus one for data in/out |
| busy | output | 1 | Operation in progress |
| req_denied | output | 1 | One-clock pulse when a request is refused by protection |
| wr_byte | input | 8 | Next byte to write |
| wr_take | output | 1 | wr_byte consumed at this clock edge |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | rd_data holds a new byte |
| prot_en | input | 1 | Protect control; blocks modify sequences |
| cfg_lo | input | 4 | Strobe low phase in clocks |
| cfg_hi | input | 4 | Strobe high phase in clocks |
| cfg_standby | input | 16 | Standby chip-select high time in clocks |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_wp_n | output | 1 | Write protect, active low |
| fl_dq_o | output | 8 | Data bus output value |
| fl_dq_oe | output | 1 | Data bus driver enable |
| fl_dq_i | input | 8 | Data bus input value |

## Verification
The assertions assume the host presents a new request only while req_ready is high. They also assume wr_byte holds the next byte whenever wr_take is high, and that the flash keeps fl_dq_i steady from the clock after the read strobe falls until it rises. The bench drives every request with a single valid cycle from an idle state. It advances wr_byte only on the clock edge that consumes the previous byte. Its flash model changes the read bus only on the clock after each falling read strobe, so with phases of at least two clocks the sampled value is always settled.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_CMD  = 3'd0,
    OP_ADDR = 3'd1,
    OP_WR   = 3'd2,
    OP_RD   = 3'd3,
    OP_STBY = 3'd4
  } nbs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_STBY  = 3'd4
  } nbs_st_e;
endpackage

// File: rtl/nbs_phase_timer.sv
// Down-counter for strobe phases and standby; loads are clamped to a floor.
module nbs_phase_timer #(
  parameter int TW   = 16,
  parameter int MINW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  localparam logic [TW-1:0] FLOOR = TW'(MINW);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val < FLOOR) ? FLOOR : load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == TW'(1));

  // R6
  timer_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q >= FLOOR));
endmodule

// File: rtl/nbs_pin_map.sv
// Decodes bus pin levels from the sequencer state and the current operation.
module nbs_pin_map import nbs_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  nbs_st_e st,
  input  nbs_op_e op,
  output logic    ce_n,
  output logic    cle,
  output logic    ale,
  output logic    we_n,
  output logic    re_n,
  output logic    dq_oe
);
  logic active, strobe;

  assign active = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH);
  assign strobe = (st == ST_LOW);

  assign ce_n  = !active;
  assign cle   = active && (op == OP_CMD);
  assign ale   = active && (op == OP_ADDR);
  assign we_n  = !(strobe && (op != OP_RD));
  assign re_n  = !(strobe && (op == OP_RD));
  assign dq_oe = active && (op != OP_RD);

  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R5
  read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq import nbs_pkg::*; #(
  parameter int PW      = 4,
  parameter int SW      = 16,
  parameter int LW      = 8,
  parameter int COL_W   = 12,
  parameter int ROW_W   = 19,
  parameter int COL_CYC = 2,
  parameter int ROW_CYC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_op,
  input  logic                   req_modify,
  input  logic [BYTE_W-1:0]      req_byte,
  input  logic [COL_W+ROW_W-1:0] req_addr,
  input  logic [LW-1:0]          req_len,
  output logic                   busy,
  output logic                   req_denied,
  input  logic [BYTE_W-1:0]      wr_byte,
  output logic                   wr_take,
  output logic [BYTE_W-1:0]      rd_data,
  output logic                   rd_valid,
  input  logic                   prot_en,
  input  logic [PW-1:0]          cfg_lo,
  input  logic [PW-1:0]          cfg_hi,
  input  logic [SW-1:0]          cfg_standby,
  output logic                   fl_ce_n,
  output logic                   fl_cle,
  output logic                   fl_ale,
  output logic                   fl_we_n,
  output logic                   fl_re_n,
  output logic                   fl_wp_n,
  output logic [BYTE_W-1:0]      fl_dq_o,
  output logic                   fl_dq_oe,
  input  logic [BYTE_W-1:0]      fl_dq_i
);
  localparam int ADDR_W   = COL_W + ROW_W;
  localparam int ADDR_CYC = COL_CYC + ROW_CYC;
  localparam int ASH_W    = ADDR_CYC * BYTE_W;
  localparam int COL_PAD  = COL_CYC * BYTE_W - COL_W;
  localparam int ROW_PAD  = ROW_CYC * BYTE_W - ROW_W;
  localparam int TW       = (SW > PW) ? SW : PW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  nbs_st_e            st_q, st_d;
  nbs_op_e            op_q, op_n;
  logic [LW-1:0]      idx_q, last_q, last_n;
  logic [BYTE_W-1:0]  dq_q, dq_n, rd_q;
  logic [ASH_W-1:0]   ash_q, ash_load;
  logic               rd_vld_q, den_q;
  logic               acc, modify, refuse, advance, capture;
  logic               tmr_load, tmr_exp;
  logic [TW-1:0]      tmr_val;

  always_comb begin
    case (req_op)
      3'd0:    op_n = OP_CMD;
      3'd1:    op_n = OP_ADDR;
      3'd2:    op_n = OP_WR;
      3'd3:    op_n = OP_RD;
      default: op_n = OP_STBY;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = !req_ready;
  assign acc       = req_valid && req_ready;
  assign modify    = (op_n == OP_WR) || ((op_n == OP_CMD) && req_modify);
  assign refuse    = prot_en && modify;

  assign ash_load = {{ROW_PAD{1'b0}}, req_addr[ADDR_W-1:COL_W],
                     {COL_PAD{1'b0}}, req_addr[COL_W-1:0]};

  always_comb begin
    case (op_n)
      OP_ADDR:      last_n = LW'(ADDR_CYC - 1);
      OP_WR, OP_RD: last_n = req_len;
      default:      last_n = '0;
    endcase
  end

  // next-state and phase timing
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    advance  = 1'b0;
    capture  = 1'b0;
    case (st_q)
      ST_IDLE: if (acc && !refuse) begin
        if (op_n == OP_STBY) begin
          st_d     = ST_STBY;
          tmr_load = 1'b1;
          tmr_val  = TW'(cfg_standby);
        end else begin
          st_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        st_d     = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = TW'(cfg_lo);
      end
      ST_LOW: if (tmr_exp) begin
        st_d     = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TW'(cfg_hi);
        capture  = (op_q == OP_RD);
      end
      ST_HIGH: if (tmr_exp) begin
        if (idx_q == last_q) begin
          st_d = ST_IDLE;
        end else begin
          st_d     = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = TW'(cfg_lo);
          advance  = 1'b1;
        end
      end
      ST_STBY: if (tmr_exp) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // byte placed on the bus for the next strobe
  always_comb begin
    dq_n = dq_q;
    if (acc && !refuse) begin
      case (op_n)
        OP_CMD:  dq_n = req_byte;
        OP_ADDR: dq_n = ash_load[BYTE_W-1:0];
        OP_WR:   dq_n = wr_byte;
        default: dq_n = dq_q;
      endcase
    end else if (advance) begin
      case (op_q)
        OP_ADDR: dq_n = ash_q[2*BYTE_W-1:BYTE_W];
        OP_WR:   dq_n = wr_byte;
        default: dq_n = dq_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_CMD;
      idx_q    <= '0;
      last_q   <= '0;
      dq_q     <= '0;
      ash_q    <= '0;
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
      den_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      dq_q     <= dq_n;
      rd_vld_q <= capture;
      den_q    <= acc && refuse;
      if (acc) begin
        op_q   <= op_n;
        last_q <= last_n;
        idx_q  <= '0;
        ash_q  <= ash_load;
      end else if (advance) begin
        idx_q  <= idx_q + LW'(1);
        ash_q  <= ash_q >> BYTE_W;
      end
      if (capture) rd_q <= fl_dq_i;
    end
  end

  nbs_phase_timer #(.TW(TW), .MINW(2)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_exp)
  );

  nbs_pin_map u_pins (
    .clk   (clk),
    .rst_n (srst_n),
    .st    (st_q),
    .op    (op_q),
    .ce_n  (fl_ce_n),
    .cle   (fl_cle),
    .ale   (fl_ale),
    .we_n  (fl_we_n),
    .re_n  (fl_re_n),
    .dq_oe (fl_dq_oe)
  );

  assign wr_take    = (acc && !refuse && (op_n == OP_WR)) || (advance && (op_q == OP_WR));
  assign fl_wp_n    = !prot_en;
  assign fl_dq_o    = dq_q;
  assign rd_data    = rd_q;
  assign rd_valid   = rd_vld_q;
  assign req_denied = den_q;

  // R7
  refuse_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc && refuse) |=> (!busy && fl_ce_n));

  // R10
  start_ce_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc && !refuse && (op_n != OP_STBY)) |=> (!fl_ce_n && fl_we_n && fl_re_n));

  // R9
  stby_ce_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_STBY) |-> fl_ce_n);

  // R4
  take_strobe_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_take && !acc) |=> !fl_we_n);
endmodule

// File: tb/nand_bus_seq_test.sv
module nand_bus_seq_test;
  typedef struct packed {
    logic [2:0]  op;
    logic        modify;
    logic        prot;
    logic [3:0]  lo;
    logic [3:0]  hi;
    logic [7:0]  len;
    logic [7:0]  cb;
    logic [30:0] addr;
  } vec_t;

  // op, modify, prot, lo, hi, len, command byte, address
  localparam vec_t VT [10] = '{
    '{3'd0, 1'b0, 1'b0, 4'd3,  4'd2, 8'd0, 8'h70, 31'h0},
    '{3'd0, 1'b1, 1'b0, 4'd2,  4'd3, 8'd0, 8'h80, 31'h0},
    '{3'd1, 1'b0, 1'b0, 4'd2,  4'd2, 8'd0, 8'h00, 31'h5ABCD123},
    '{3'd1, 1'b0, 1'b0, 4'd4,  4'd5, 8'd0, 8'h00, 31'h7FFFFFFF},
    '{3'd2, 1'b0, 1'b0, 4'd2,  4'd2, 8'd3, 8'h00, 31'h0},
    '{3'd3, 1'b0, 1'b0, 4'd3,  4'd2, 8'd4, 8'h00, 31'h0},
    '{3'd2, 1'b0, 1'b1, 4'd2,  4'd2, 8'd2, 8'h00, 31'h0},
    '{3'd0, 1'b1, 1'b1, 4'd2,  4'd2, 8'd0, 8'h60, 31'h0},
    '{3'd3, 1'b0, 1'b1, 4'd0,  4'd1, 8'd1, 8'h00, 31'h0},
    '{3'd0, 1'b0, 1'b1, 4'd15, 4'd4, 8'd0, 8'hFF, 31'h0}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_modify, busy, req_denied;
  logic [2:0] req_op;
  logic [7:0] req_byte, req_len, wr_byte, rd_data, fl_dq_o;
  logic [30:0] req_addr;
  logic wr_take, rd_valid, prot_en;
  logic [3:0] cfg_lo, cfg_hi;
  logic [15:0] cfg_standby;
  logic fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_wp_n, fl_dq_oe;
  logic [7:0] dev_q;

  nand_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_modify(req_modify), .req_byte(req_byte),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .req_denied(req_denied),
    .wr_byte(wr_byte), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .prot_en(prot_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_standby(cfg_standby),
    .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
    .fl_re_n(fl_re_n), .fl_wp_n(fl_wp_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(dev_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int total  = 0;
  int cyc    = 0;

  function automatic logic [7:0] wpat(int i);
    return 8'(8'h3C + i * 8'h11);
  endfunction

  function automatic logic [7:0] rpat(int i);
    return 8'(8'hC3 ^ (i * 8'h27));
  endfunction

  // host write source: advances only on the edge that consumes a byte
  int wcnt = 0;
  int wbase = 0;
  always @(posedge clk) if (wr_take) wcnt <= wcnt + 1;
  assign wr_byte = wpat(wcnt - wbase);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL WD watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, total + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor state
  logic [7:0] we_cap [0:63];
  logic [7:0] rd_cap [0:63];
  int nwe, nre, nrd, lvl, busy_n, setup_n, den, ready_bad, dev_k, cur_op;
  int lo_run, hi_run, lo_min, lo_max, hi_min, hi_max;
  bit seen, trk, pw, pr;

  task automatic rec_lo();
    if (lo_run < lo_min) lo_min = lo_run;
    if (lo_run > lo_max) lo_max = lo_run;
    lo_run = 0;
  endtask

  task automatic rec_hi();
    if (hi_run < hi_min) hi_min = hi_run;
    if (hi_run > hi_max) hi_max = hi_run;
    hi_run = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    if (!fl_ce_n && !seen && fl_we_n && fl_re_n) setup_n++;
    if (!fl_we_n || !fl_re_n) begin
      seen = 1;
      if (hi_run > 0) rec_hi();
      lo_run++;
    end else begin
      if (lo_run > 0) begin rec_lo(); trk = 1; end
      if (trk) begin
        if (!fl_ce_n) hi_run++;
        else begin rec_hi(); trk = 0; end
      end
    end
    if (!pw && fl_we_n) begin
      if (nwe < 64) we_cap[nwe] = fl_dq_o;
      nwe++;
      if (fl_ce_n || !fl_re_n || (fl_cle != (cur_op == 0)) || (fl_ale != (cur_op == 1))
          || ((cur_op == 2) && !fl_wp_n)) lvl++;
    end
    if (!pr && fl_re_n) begin
      nre++;
      if (fl_ce_n || !fl_we_n || fl_cle || fl_ale) lvl++;
    end
    if (pr && !fl_re_n) begin
      dev_q = rpat(dev_k);
      dev_k++;
    end
    if ((cur_op == 3) && !fl_ce_n && fl_dq_oe) lvl++;
    if (busy && (cur_op >= 4) && !fl_ce_n) lvl++;
    if (busy) busy_n++;
    if (busy == req_ready) ready_bad++;
    if (rd_valid) begin
      if (nrd < 64) rd_cap[nrd] = rd_data;
      nrd++;
    end
    if (req_denied) den++;
    pw = fl_we_n;
    pr = fl_re_n;
  endtask

  function automatic logic [7:0] exp_byte(vec_t v, int i);
    logic [39:0] a40;
    a40 = {5'b0, v.addr[30:12], 4'b0, v.addr[11:0]};
    case (v.op)
      3'd0:    return v.cb;
      3'd1:    return a40[8*i +: 8];
      default: return wpat(i);
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int n, lw, hw, sw, exp_we, exp_re, exp_busy, g;
    bit refd, stby;
    string tag;
    nwe = 0; nre = 0; nrd = 0; lvl = 0; busy_n = 0; setup_n = 0; den = 0;
    ready_bad = 0; dev_k = 0; lo_run = 0; hi_run = 0; lo_min = 999; lo_max = 0;
    hi_min = 999; hi_max = 0; seen = 0; trk = 0; pw = 1; pr = 1;
    cur_op = int'(v.op);
    wbase = wcnt;
    stby = (v.op >= 3'd4);
    refd = v.prot && ((v.op == 3'd2) || ((v.op == 3'd0) && v.modify));
    n  = (v.op == 3'd0) ? 1 : (v.op == 3'd1) ? 5 : int'(v.len) + 1;
    lw = (v.lo < 4'd2) ? 2 : int'(v.lo);
    hw = (v.hi < 4'd2) ? 2 : int'(v.hi);
    sw = (cfg_standby < 16'd2) ? 2 : int'(cfg_standby);
    tag = refd ? "R7" : stby ? "R9" : (v.op == 3'd0) ? "R2" : (v.op == 3'd1) ? "R3"
        : (v.op == 3'd2) ? "R4" : "R5";
    exp_we   = (!refd && !stby && (v.op <= 3'd2)) ? n : 0;
    exp_re   = (v.op == 3'd3) ? n : 0;
    exp_busy = refd ? 0 : stby ? sw : 1 + n * (lw + hw);

    prot_en = v.prot; cfg_lo = v.lo; cfg_hi = v.hi;
    req_op = v.op; req_modify = v.modify; req_byte = v.cb;
    req_addr = v.addr; req_len = v.len; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    g = 0;
    while (busy && g < 5000) begin tick(); g++; end
    check(g < 5000, "WD operation hung", g, 5000);
    tick(); tick();

    check(nwe == exp_we, {tag, " write strobe count"}, nwe, exp_we);
    check(nre == exp_re, {tag, " read strobe count"}, nre, exp_re);
    for (int i = 0; i < exp_we && i < 64; i++)
      check(we_cap[i] == exp_byte(v, i), {tag, " latched byte"}, we_cap[i], exp_byte(v, i));
    check(nrd == exp_re, {tag, " rd_valid count"}, nrd, exp_re);
    for (int i = 0; i < exp_re && i < 64; i++)
      check(rd_cap[i] == rpat(i), "R5 read byte", rd_cap[i], rpat(i));
    check(lvl == 0, {tag, " bus level violations"}, lvl, 0);
    if (v.op == 3'd2)
      check((wcnt - wbase) == (refd ? 0 : n), {tag, " wr_take count"}, wcnt - wbase, refd ? 0 : n);
    if (exp_we + exp_re > 0) begin
      check(lo_min == lw && lo_max == lw, "R6 strobe low width", lo_max, lw);
      check(hi_min == hw && hi_max == hw, "R6 strobe high width", hi_max, hw);
    end
    check(busy_n == exp_busy, stby ? "R9 standby busy clocks" : "R10 busy clocks", busy_n, exp_busy);
    check(setup_n == ((refd || stby) ? 0 : 1), "R10 chip-select lead", setup_n, (refd || stby) ? 0 : 1);
    check(den == (refd ? 1 : 0), "R7 denied pulse", den, refd ? 1 : 0);
    check(ready_bad == 0, "R10 ready versus busy", ready_bad, 0);
  endtask

  task automatic check_idle(input string tag);
    check(fl_ce_n && fl_we_n && fl_re_n, {tag, " strobes idle"}, {fl_ce_n, fl_we_n, fl_re_n}, 3'b111);
    check(!fl_cle && !fl_ale && !fl_dq_oe, {tag, " latches and driver off"}, {fl_cle, fl_ale, fl_dq_oe}, 0);
    check(!busy && req_ready, {tag, " busy/ready"}, {busy, req_ready}, 2'b01);
  endtask

  initial begin
    vec_t sv;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_modify = 1'b0; req_byte = '0;
    req_addr = '0; req_len = '0; prot_en = 1'b0; cfg_lo = 4'd2; cfg_hi = 4'd2;
    cfg_standby = 16'd20; dev_q = '0; pw = 1; pr = 1;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after release");

    // main table
    for (int k = 0; k < 10; k++) run_vec(VT[k]);

    // standby with a programmed interval and with a value under the floor
    sv = '{3'd4, 1'b0, 1'b0, 4'd2, 4'd2, 8'd0, 8'h00, 31'h0};
    prot_en = 1'b0;
    cfg_standby = 16'd20;
    run_vec(sv);
    cfg_standby = 16'd1;
    sv.op = 3'd7;
    run_vec(sv);

    // protect pin follows the control level with no clock involved
    prot_en = 1'b1; #1;
    check(fl_wp_n == 1'b0, "R8 wp_n low when protected", fl_wp_n, 0);
    prot_en = 1'b0; #1;
    check(fl_wp_n == 1'b1, "R8 wp_n high when released", fl_wp_n, 1);

    check_idle("R1 end idle");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule